// File: doc/BRIEF.md
# Private Peripheral Window Access Decoder

This block is the slave-side entry point to the private register space of a multi-core cluster. It accepts single requests over a valid/ready handshake and claims those whose upper address bits match a configured base. The claimed space is an 8KB window made of two 4KB pages. Inside the window, the block works out which of five register targets the offset falls on. The targets are snoop control, interrupt CPU interface, global timer, private timers/watchdogs and interrupt distributor. For each accepted request the block then decides whether the access is allowed. A legal access raises exactly one target select for the handshake cycle. An illegal access gets an error response, and no target sees it.

Control is a two-state machine. In `ST_IDLE` the block offers `req_ready` for in-window addresses. Transition `T_ACCEPT` (request handshake) moves to `ST_RESP`, which presents a registered response until `resp_ready`. Transition `T_RETIRE` (response handshake) returns to `ST_IDLE`. Addresses outside the window are never claimed. For them the block raises `req_miss`, so that an upstream interconnect can route the request elsewhere.

Top module: `ppr_decoder`

## Requirements
- R1: A request hits when `req_addr[31:13]` equals `cfg_base`. Otherwise `req_miss` is high while `req_valid` is high, `req_ready` is low, no select rises and no response is produced.
- R2: For an in-window offset, pages 0x000-0x0FF go to `pp_sel[0]` (snoop control) and 0x100-0x1FF go to `pp_sel[1]` (interrupt CPU interface). Pages 0x200-0x2FF go to `pp_sel[2]` (global timer), 0x600-0x6FF go to `pp_sel[3]` (private timers/watchdogs) and 0x1000-0x1FFF go to `pp_sel[4]` (distributor).
- R3: Offsets 0x300-0x5FF and 0x700-0xFFF are holes. Any access to them gets `resp_err`=1 and raises no select.
- R4: The global timer and private timer targets accept only word accesses. `req_size` is encoded 0=byte, 1=halfword, 2=word, 3=doubleword. A byte, halfword or doubleword access to these targets gets `resp_err`=1 and has no effect on the target.
- R5: The snoop control, interrupt CPU interface and distributor targets accept byte and word accesses. A halfword or doubleword access to them gets `resp_err`=1.
- R6: A word access with `req_strb` not equal to 4'hF gets `resp_err`=1 and has no effect on the target.
- R7: A request with `req_multi`=1 (multi-beat) gets `resp_err`=1 and is not forwarded.
- R8: A request whose `req_src` equals the coherency-port ID (default 7) gets `resp_err`=1 and reaches no target.
- R9: Each accepted legal request raises exactly one bit of `pp_sel`, during its handshake cycle only. No select is high outside a handshake.
- R10: `resp_valid` rises in the cycle after the handshake. `resp_err`, `resp_rdata` and `resp_valid` hold until `resp_ready`, and `req_ready` stays low meanwhile. A legal read returns the target word. Writes and errored accesses return zero data.
- R11: Lanes are little-endian. A byte access drives `pp_strb` with only lane `req_addr[1:0]` set. A word access drives all four lanes. Write and read data pass through with no lane swap.
- R12: After reset `resp_valid` is low and `pp_sel` is zero, and the block is in `ST_IDLE` with `req_ready` high for an in-window address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 19 | Window base, compared with address bits 31:13 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| req_strb | input | 4 | Byte strobes, lane n = address offset n |
| req_multi | input | 1 | Request is part of a multi-beat transfer |
| req_write | input | 1 | 1 write, 0 read |
| req_src | input | 3 | Source identifier |
| req_wdata | input | 32 | Write data |
| req_miss | output | 1 | Valid request outside the window |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response taken |
| resp_err | output | 1 | 1 slave error, 0 okay |
| resp_rdata | output | 32 | Read data |
| pp_sel | output | 5 | One-hot target select |
| pp_write | output | 1 | Forwarded write flag |
| pp_word | output | 11 | Word offset inside window (address bits 12:2) |
| pp_strb | output | 4 | Forwarded lane strobes |
| pp_wdata | output | 32 | Forwarded write data |
| pp_rdata | input | 160 | Read data of the targets, target t at bits 32t+31:32t |

## Verification
A pending response and a newly arriving request can share a cycle. The bench holds `resp_ready` low after a timer read and presents a legal in-window write to the same timer during the wait. It then checks, cycle by cycle, that `req_ready` and every select stay low while the response holds still. A later read must show that the timer kept its old value. In the same wait window an out-of-range address is also presented. This confirms that the miss indication still works while the machine is busy.

// File: rtl/ppr_pkg.sv
`timescale 1ns/1ps
package ppr_pkg;

    // Window geometry: two 4KB pages, decoded in 256-byte pages
    localparam int WIN_BITS = 13;
    localparam int PAGE_SH  = 8;
    localparam int PAGE_W   = WIN_BITS - PAGE_SH;
    localparam int NUM_TGT  = 5;

    // Target indices
    localparam int T_SNOOP = 0;
    localparam int T_ICPU  = 1;
    localparam int T_GTMR  = 2;
    localparam int T_PTMR  = 3;
    localparam int T_DIST  = 4;

    // First page and page count per target (256-byte units)
    localparam int TGT_LO   [NUM_TGT] = '{0, 1, 2, 6, 16};
    localparam int TGT_SPAN [NUM_TGT] = '{1, 1, 1, 1, 16};

    // Allowed sizes per target, bit i = size code i
    localparam logic [3:0] TGT_SIZES [NUM_TGT] =
        '{4'b0101, 4'b0101, 4'b0100, 4'b0100, 4'b0101};

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

endpackage

// File: rtl/ppr_region_match.sv
`timescale 1ns/1ps
module ppr_region_match
    import ppr_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int BASE_W = ADDR_W - WIN_BITS,
    localparam int HI_W   = ADDR_W - PAGE_SH
) (
    input  logic [HI_W-1:0]    addr_hi,
    input  logic [BASE_W-1:0]  base,
    output logic               in_win,
    output logic [NUM_TGT-1:0] tgt_hit,
    output logic               hole
);

    logic [PAGE_W:0] page;

    assign in_win = (addr_hi[HI_W-1:PAGE_W] == base);
    assign page   = {1'b0, addr_hi[PAGE_W-1:0]};

    // One range compare per target; wrap-around subtraction keeps it a single compare
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_rng
        localparam logic [PAGE_W:0] LO_T   = (PAGE_W+1)'(TGT_LO[t]);
        localparam logic [PAGE_W:0] SPAN_T = (PAGE_W+1)'(TGT_SPAN[t]);
        logic [PAGE_W:0] rel;
        assign rel        = page - LO_T;
        assign tgt_hit[t] = (rel < SPAN_T);
    end

    assign hole = ~|tgt_hit;

endmodule

// File: rtl/ppr_access_check.sv
`timescale 1ns/1ps
module ppr_access_check
    import ppr_pkg::*;
#(
    parameter int SRC_W  = 3,
    parameter int STRB_W = 4,
    parameter logic [SRC_W-1:0] COH_SRC = SRC_W'(7),
    localparam int LANE_W = $clog2(STRB_W)
) (
    input  logic [NUM_TGT-1:0] tgt_hit,
    input  logic               hole,
    input  size_e              size,
    input  logic [STRB_W-1:0]  strb,
    input  logic [LANE_W-1:0]  lane,
    input  logic               multi,
    input  logic [SRC_W-1:0]   src,
    output logic               err,
    output logic [STRB_W-1:0]  fwd_strb
);

    logic [NUM_TGT-1:0] size_ok;
    logic               from_coh;
    logic               partial;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_sz
        assign size_ok[t] = tgt_hit[t] & TGT_SIZES[t][size];
    end

    assign from_coh = (src == COH_SRC);
    assign partial  = (size == SZ_WORD) && (strb != {STRB_W{1'b1}});

    always_comb begin
        err = 1'b0;
        if (from_coh)      err = 1'b1;
        else if (multi)    err = 1'b1;
        else if (hole)     err = 1'b1;
        else if (~|size_ok) err = 1'b1;
        else if (partial)  err = 1'b1;
    end

    // Little-endian lanes: byte lane n carries offset n
    always_comb begin
        if (size == SZ_BYTE) fwd_strb = STRB_W'(1) << lane;
        else                 fwd_strb = {STRB_W{1'b1}};
    end

endmodule

// File: rtl/ppr_resp_fsm.sv
`timescale 1ns/1ps
module ppr_resp_fsm
    import ppr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              in_win,
    input  logic              err,
    input  logic              is_write,
    input  logic [DATA_W-1:0] tgt_rdata,
    input  logic              resp_ready,
    output logic              req_ready,
    output logic              accept,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata
);

    state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: T_ACCEPT and T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)     state_d = ST_RESP;
            ST_RESP: if (resp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready  = in_win;
            ST_RESP: resp_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = req_valid & req_ready;

    // Response capture at the request handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else if (accept) begin
            resp_err   <= err;
            resp_rdata <= (!err && !is_write) ? tgt_rdata : '0;
        end
    end

endmodule

// File: rtl/ppr_decoder.sv
`timescale 1ns/1ps
module ppr_decoder
    import ppr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SRC_W  = 3,
    parameter logic [SRC_W-1:0] COH_SRC = SRC_W'(7),
    localparam int BASE_W = ADDR_W - WIN_BITS,
    localparam int STRB_W = DATA_W / 8,
    localparam int LANE_W = $clog2(STRB_W),
    localparam int WORD_W = WIN_BITS - LANE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BASE_W-1:0]         cfg_base,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [1:0]                req_size,
    input  logic [STRB_W-1:0]         req_strb,
    input  logic                      req_multi,
    input  logic                      req_write,
    input  logic [SRC_W-1:0]          req_src,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      req_miss,
    output logic                      resp_valid,
    input  logic                      resp_ready,
    output logic                      resp_err,
    output logic [DATA_W-1:0]         resp_rdata,
    output logic [NUM_TGT-1:0]        pp_sel,
    output logic                      pp_write,
    output logic [WORD_W-1:0]         pp_word,
    output logic [STRB_W-1:0]         pp_strb,
    output logic [DATA_W-1:0]         pp_wdata,
    input  logic [NUM_TGT*DATA_W-1:0] pp_rdata
);

    logic               in_win;
    logic [NUM_TGT-1:0] tgt_hit;
    logic               hole;
    logic               err;
    logic               accept;
    logic [DATA_W-1:0]  tgt_rdata;

    ppr_region_match #(.ADDR_W(ADDR_W)) u_match (
        .addr_hi (req_addr[ADDR_W-1:PAGE_SH]),
        .base    (cfg_base),
        .in_win  (in_win),
        .tgt_hit (tgt_hit),
        .hole    (hole)
    );

    ppr_access_check #(
        .SRC_W   (SRC_W),
        .STRB_W  (STRB_W),
        .COH_SRC (COH_SRC)
    ) u_check (
        .tgt_hit  (tgt_hit),
        .hole     (hole),
        .size     (size_e'(req_size)),
        .strb     (req_strb),
        .lane     (req_addr[LANE_W-1:0]),
        .multi    (req_multi),
        .src      (req_src),
        .err      (err),
        .fwd_strb (pp_strb)
    );

    // AND-OR read mux over the one-hot target hit
    always_comb begin
        tgt_rdata = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (tgt_hit[t]) tgt_rdata = tgt_rdata | pp_rdata[t*DATA_W +: DATA_W];
        end
    end

    ppr_resp_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .in_win     (in_win),
        .err        (err),
        .is_write   (req_write),
        .tgt_rdata  (tgt_rdata),
        .resp_ready (resp_ready),
        .req_ready  (req_ready),
        .accept     (accept),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata)
    );

    assign req_miss = req_valid & ~in_win;
    assign pp_sel   = (accept && !err) ? tgt_hit : '0;
    assign pp_write = req_write;
    assign pp_word  = req_addr[WIN_BITS-1:LANE_W];
    assign pp_wdata = req_wdata;

endmodule

// File: rtl/ppr_decoder_chk.sv
`timescale 1ns/1ps
module ppr_decoder_chk #(
    parameter int NT     = 5,
    parameter int SRC_W  = 3,
    parameter int STRB_W = 4,
    parameter int DATA_W = 32,
    parameter logic [SRC_W-1:0] COH_SRC = SRC_W'(7)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_size,
    input logic [STRB_W-1:0] req_strb,
    input logic              req_multi,
    input logic [SRC_W-1:0]  req_src,
    input logic              req_miss,
    input logic              resp_valid,
    input logic              resp_ready,
    input logic              resp_err,
    input logic [DATA_W-1:0] resp_rdata,
    input logic [NT-1:0]     pp_sel
);

    a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pp_sel));

    a_r9_sel_in_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (|pp_sel) |-> (req_valid && req_ready));

    a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_err) && $stable(resp_rdata)));

    a_r10_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    a_r1_miss_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        req_miss |-> (!req_ready && pp_sel == '0));

    a_r8_coh_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == COH_SRC) |-> (pp_sel == '0));

    a_r7_multi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_multi) |-> (pp_sel == '0));

    a_r6_partial_word: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd2 && req_strb != {STRB_W{1'b1}}) |-> (pp_sel == '0));

endmodule

bind ppr_decoder ppr_decoder_chk #(
    .NT      (ppr_pkg::NUM_TGT),
    .SRC_W   (SRC_W),
    .STRB_W  (STRB_W),
    .DATA_W  (DATA_W),
    .COH_SRC (COH_SRC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_size   (req_size),
    .req_strb   (req_strb),
    .req_multi  (req_multi),
    .req_src    (req_src),
    .req_miss   (req_miss),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata),
    .pp_sel     (pp_sel)
);

// File: tb/ppr_decoder_bench.sv
`timescale 1ns/1ps
module ppr_decoder_bench;

    localparam logic [18:0] BASE = 19'h7A5C3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic [3:0]   req_strb = '0;
    logic         req_multi = 1'b0;
    logic         req_write = 1'b0;
    logic [2:0]   req_src = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_miss;
    logic         resp_valid;
    logic         resp_ready = 1'b0;
    logic         resp_err;
    logic [31:0]  resp_rdata;
    logic [4:0]   pp_sel;
    logic         pp_write;
    logic [10:0]  pp_word;
    logic [3:0]   pp_strb;
    logic [31:0]  pp_wdata;
    logic [159:0] pp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ppr_decoder u_ppr_decoder (
        .clk, .rst_n, .cfg_base(BASE), .req_valid, .req_ready, .req_addr,
        .req_size, .req_strb, .req_multi, .req_write, .req_src, .req_wdata,
        .req_miss, .resp_valid, .resp_ready, .resp_err, .resp_rdata,
        .pp_sel, .pp_write, .pp_word, .pp_strb, .pp_wdata, .pp_rdata
    );

    // Register stubs: one word per target
    logic [31:0] stub [5];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 5; t++) stub[t] <= '0;
        end else begin
            for (int t = 0; t < 5; t++) begin
                if (pp_sel[t] && pp_write) begin
                    for (int b = 0; b < 4; b++)
                        if (pp_strb[b]) stub[t][b*8 +: 8] <= pp_wdata[b*8 +: 8];
                end
            end
        end
    end
    always_comb begin
        for (int t = 0; t < 5; t++) pp_rdata[t*32 +: 32] = stub[t];
    end

    // Bench model of target contents
    logic [31:0] model [5];

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    typedef struct packed {
        logic [12:0] off;
        logic [1:0]  size;
        logic [3:0]  strb;
        logic        multi;
        logic [2:0]  src;
        logic        wr;
        logic [31:0] wdata;
        logic        err;
        logic [2:0]  tgt;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{13'h0004, 2'd2, 4'hF, 1'b0, 3'd0, 1'b1, 32'h11223344, 1'b0, 3'd0, 4'd2 },  // R2 snoop word write
        '{13'h0004, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd0, 4'd10},  // R10 read back
        '{13'h0006, 2'd0, 4'h0, 1'b0, 3'd0, 1'b1, 32'hAABBCCDD, 1'b0, 3'd0, 4'd11},  // R11 byte lane 2
        '{13'h0000, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd0, 4'd11},  // R11 read merged word
        '{13'h0002, 2'd1, 4'hC, 1'b0, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 3'd0, 4'd5 },  // R5 half to snoop
        '{13'h0100, 2'd2, 4'hF, 1'b0, 3'd0, 1'b1, 32'hCAFEF00D, 1'b0, 3'd1, 4'd2 },  // R2 icpu
        '{13'h0101, 2'd0, 4'h0, 1'b0, 3'd0, 1'b1, 32'h00005A00, 1'b0, 3'd1, 4'd11},  // R11 byte lane 1
        '{13'h0104, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd1, 4'd11},  // R11 read
        '{13'h0200, 2'd2, 4'hF, 1'b0, 3'd0, 1'b1, 32'h01234567, 1'b0, 3'd2, 4'd2 },  // R2 global timer
        '{13'h0200, 2'd0, 4'h0, 1'b0, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 3'd2, 4'd4 },  // R4 byte to timer
        '{13'h0204, 2'd3, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b1, 3'd2, 4'd4 },  // R4 dword
        '{13'h0600, 2'd2, 4'hF, 1'b0, 3'd0, 1'b1, 32'h89ABCDEF, 1'b0, 3'd3, 4'd2 },  // R2 private timer
        '{13'h0600, 2'd1, 4'h3, 1'b0, 3'd0, 1'b0, 32'h0,        1'b1, 3'd3, 4'd4 },  // R4 half read
        '{13'h0600, 2'd2, 4'h7, 1'b0, 3'd0, 1'b1, 32'h00000000, 1'b1, 3'd3, 4'd6 },  // R6 partial strobe
        '{13'h1FFC, 2'd2, 4'hF, 1'b0, 3'd0, 1'b1, 32'h0F0F0F0F, 1'b0, 3'd4, 4'd2 },  // R2 distributor top
        '{13'h1003, 2'd0, 4'h0, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd4, 4'd5 },  // R5 byte read dist
        '{13'h1000, 2'd1, 4'h3, 1'b0, 3'd0, 1'b0, 32'h0,        1'b1, 3'd4, 4'd5 },  // R5 half to dist
        '{13'h0300, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b1, 3'd5, 4'd3 },  // R3 hole low edge
        '{13'h05FC, 2'd2, 4'hF, 1'b0, 3'd0, 1'b1, 32'h12345678, 1'b1, 3'd5, 4'd3 },  // R3 hole high edge
        '{13'h0700, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b1, 3'd5, 4'd3 },  // R3 second hole
        '{13'h0FFC, 2'd2, 4'hF, 1'b0, 3'd0, 1'b1, 32'h0,        1'b1, 3'd5, 4'd3 },  // R3 last hole word
        '{13'h0004, 2'd2, 4'hF, 1'b1, 3'd0, 1'b1, 32'hDEADBEEF, 1'b1, 3'd0, 4'd7 },  // R7 multi-beat
        '{13'h1FFC, 2'd2, 4'hF, 1'b0, 3'd7, 1'b1, 32'hDEADBEEF, 1'b1, 3'd4, 4'd8 },  // R8 coherency source
        '{13'h00FC, 2'd2, 4'hF, 1'b0, 3'd6, 1'b0, 32'h0,        1'b0, 3'd0, 4'd2 },  // R2 snoop top, src 6
        '{13'h01FC, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd1, 4'd2 },  // R2 icpu top
        '{13'h0200, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd2, 4'd4 },  // R4 no effect shown
        '{13'h06FC, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd3, 4'd6 },  // R6 no effect shown
        '{13'h1FFC, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd4, 4'd8 },  // R8 no effect shown
        '{13'h0000, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0,        1'b0, 3'd0, 4'd7 }   // R7 no effect shown
    };

    task automatic run_vec(input vec_t v);
        string       tag;
        logic [4:0]  exp_sel;
        logic [3:0]  exp_strb;
        logic [31:0] exp_rd;
        tag = $sformatf("R%0d vec off=%h", v.rq, v.off);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {BASE, v.off};
        req_size  = v.size;
        req_strb  = v.strb;
        req_multi = v.multi;
        req_src   = v.src;
        req_write = v.wr;
        req_wdata = v.wdata;
        resp_ready = 1'b0;
        #1;
        exp_sel  = v.err ? 5'd0 : (5'd1 << v.tgt);
        exp_strb = (v.size == 2'd0) ? (4'd1 << v.off[1:0]) : 4'hF;
        exp_rd   = (!v.err && !v.wr) ? model[v.tgt] : 32'h0;
        chk(req_ready == 1'b1, {tag, " R1 ready"}, 32'(req_ready), 32'h1);
        chk(pp_sel == exp_sel, {tag, " R9 select"}, 32'(pp_sel), 32'(exp_sel));
        if (!v.err) chk(pp_strb == exp_strb, {tag, " R11 strobe"}, 32'(pp_strb), 32'(exp_strb));
        @(posedge clk);
        if (!v.err && v.wr) begin
            for (int b = 0; b < 4; b++)
                if (exp_strb[b]) model[v.tgt][b*8 +: 8] = v.wdata[b*8 +: 8];
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(resp_valid == 1'b1, {tag, " R10 resp valid"}, 32'(resp_valid), 32'h1);
        chk(resp_err == v.err, {tag, " err flag"}, 32'(resp_err), 32'(v.err));
        chk(resp_rdata == exp_rd, {tag, " R10 rdata"}, resp_rdata, exp_rd);
        chk(pp_sel == 5'd0, {tag, " R9 select after"}, 32'(pp_sel), 32'h0);
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        #1;
        chk(resp_valid == 1'b0, {tag, " R10 retire"}, 32'(resp_valid), 32'h0);
    endtask

    initial begin
        for (int t = 0; t < 5; t++) model[t] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        chk(resp_valid == 1'b0, "R12 resp_valid in reset", 32'(resp_valid), 32'h0);
        chk(pp_sel == 5'd0, "R12 pp_sel in reset", 32'(pp_sel), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        req_addr = {BASE, 13'h0000};
        #1;
        chk(req_ready == 1'b1, "R12 idle ready", 32'(req_ready), 32'h1);
        chk(resp_valid == 1'b0, "R12 idle no resp", 32'(resp_valid), 32'h0);

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R1 out-of-window requests, just above and just below
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_size  = 2'd2;
            req_strb  = 4'hF;
            req_write = 1'b1;
            req_src   = 3'd0;
            req_multi = 1'b0;
            req_addr  = (k == 0) ? ({BASE, 13'h1FFC} + 32'd4) : ({BASE, 13'h0000} - 32'd4);
            #1;
            chk(req_miss == 1'b1, "R1 miss flag", 32'(req_miss), 32'h1);
            chk(req_ready == 1'b0, "R1 not claimed", 32'(req_ready), 32'h0);
            chk(pp_sel == 5'd0, "R1 no select", 32'(pp_sel), 32'h0);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(resp_valid == 1'b0, "R1 no response", 32'(resp_valid), 32'h0);
            chk(req_miss == 1'b0, "R1 miss drops", 32'(req_miss), 32'h0);
        end

        // R10 response held while a new request waits
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {BASE, 13'h0200};
        req_size  = 2'd2;
        req_strb  = 4'hF;
        req_write = 1'b0;
        resp_ready = 1'b0;
        @(negedge clk);
        req_write = 1'b1;
        req_wdata = 32'h55AA55AA;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(resp_valid == 1'b1, "R10 held valid", 32'(resp_valid), 32'h1);
            chk(resp_rdata == model[2], "R10 held rdata", resp_rdata, model[2]);
            chk(req_ready == 1'b0, "R10 stalled ready", 32'(req_ready), 32'h0);
            chk(pp_sel == 5'd0, "R9 no select while busy", 32'(pp_sel), 32'h0);
            @(negedge clk);
        end
        req_addr = 32'h0000_1000;
        #1;
        chk(req_miss == 1'b1, "R1 miss while busy", 32'(req_miss), 32'h1);
        req_valid = 1'b0;
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        // stalled write must not have landed
        run_vec('{13'h0200, 2'd2, 4'hF, 1'b0, 3'd0, 1'b0, 32'h0, 1'b0, 3'd2, 4'd10});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule